// File: doc/BRIEF.md
# Card Slot Power-Down and Fault Sequencer

This block supervises a single card slot. It filters the mechanical presence switch, qualifies the raw fault comparator flags against a persistence window, and, whenever the supply request is withdrawn or a qualified fault appears, walks the card contacts down in a fixed order: reset first, then the clock (handled according to the clock mode), then the data contacts, and finally the supply enable.

The block sits between the command register and the contact drivers. The requested reset level, clock source and data levels pass through it. The block gates them against the supply-ready indication while the slot is live and overrides them during power-down. It returns a latched fault flag and a debounced card-present flag for the status word. All timeouts are parameters counted in system clock cycles.

Top module: `card_deact_seq`

## Requirements
- R1: While rst_ni is low, vcc_en_o, card_rst_o, card_clk_o, card_dat_o, fault_o and present_o are all 0.
- R2: present_o rises only after pres_n_i (0 = card inserted) has been sampled low on DEB_CYC consecutive clock edges. A high sample on pres_n_i clears present_o at the next edge and restarts the count.
- R3: The undervoltage, overcurrent, overtemperature and reset-mismatch flags set fault_o only after being high on FLT_CYC consecutive edges while vcc_sel_i is non-zero. A shorter burst has no effect.
- R4: The clock-mismatch flag accumulates its high cycles without clearing on low cycles. fault_o sets on the FLT_CYC-th high cycle in total.
- R5: With vcc_sel_i non-zero, a high pres_n_i or a card that is not yet debounced sets fault_o at the next edge, with no timeout. This covers card removal and a power request with no card.
- R6: fault_o stays set until vcc_sel_i reads 00 (the shutdown code), and the slot is not powered again while it is set.
- R7: Power-down starts when vcc_sel_i becomes 00 or when a fault is set. card_rst_o is 0 from the first power-down cycle onward.
- R8: In asynchronous clock mode (sync_mode_i = 0), card_clk_o follows clk_src_i until clk_fall_i reports a falling edge, and is then low. If no falling edge is reported within CLK_TO cycles, the clock is forced low.
- R9: In synchronous clock mode (sync_mode_i = 1), card_clk_o is frozen at its last level for CLK_TO cycles regardless of clk_src_i, then driven low.
- R10: card_dat_o (one bit per data contact) keeps its level during the clock step, then goes to 0 for one cycle with vcc_en_o still 1. vcc_en_o falls on the next cycle.
- R11: card_rst_o, card_clk_o and card_dat_o are never 1 while vcc_rdy_i is 0.
- R12: vcc_en_o rises one edge after vcc_sel_i becomes non-zero, provided no fault is latched and the card is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_sel_i | input | 2 | Supply request; 00 = off, any other value = on |
| pres_n_i | input | 1 | Presence switch, 0 = card inserted |
| flt_uv_i | input | 1 | Raw supply undervoltage flag |
| flt_oc_i | input | 1 | Raw supply overcurrent flag |
| flt_ot_i | input | 1 | Raw overtemperature flag |
| flt_rst_i | input | 1 | Raw reset-contact mismatch flag |
| flt_clk_i | input | 1 | Raw clock-contact mismatch flag (accumulated) |
| vcc_rdy_i | input | 1 | Card supply has reached its target |
| sync_mode_i | input | 1 | 1 = synchronous clock, 0 = asynchronous clock |
| clk_fall_i | input | 1 | Pulse: falling edge seen on the card clock |
| rst_req_i | input | 1 | Requested card reset level |
| clk_src_i | input | 1 | Selected clock source level |
| dat_i | input | DAT_W | Requested data contact levels |
| vcc_en_o | output | 1 | Card supply enable |
| card_rst_o | output | 1 | Card reset contact |
| card_clk_o | output | 1 | Card clock contact |
| card_dat_o | output | DAT_W | Card data contacts |
| fault_o | output | 1 | Latched fault status |
| present_o | output | 1 | Debounced card-present status |

## Verification
Two things can land on the same edge: the fault qualifier reaching its persistence limit and the sequencer leaving the active state. The edge on which a persistence counter expires must also be the first power-down cycle. The bench holds each fault flag for exactly FLT_CYC edges, and for one edge fewer, and expects fault_o at the following sample. Card removal with an active reset request is used the same way: fault_o must be 1 and card_rst_o 0 at the same sample, one edge after pres_n_i rises.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_LIVE = 2'd1,
    ST_CLKD = 2'd2,
    ST_DATD = 2'd3
  } seq_st_e;

  localparam int NUM_PFLT = 4;
endpackage

// File: rtl/pres_debounce.sv
module pres_debounce #(
  parameter int DEB_CYC = 32000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pres_n_i,
  output logic present_o
);
  localparam int CW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          pres_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pres_q <= 1'b0;
    end else if (pres_n_i) begin
      cnt_q  <= '0;
      pres_q <= 1'b0;
    end else if (cnt_q == LAST) begin
      pres_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign present_o = pres_q;
endmodule

// File: rtl/fault_qual.sv
module fault_qual #(
  parameter int FLT_CYC = 50,
  parameter int NP      = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [NP-1:0] pflt_i,
  input  logic          aflt_i,
  input  logic          nocard_i,
  output logic          fault_now_o,
  output logic          fault_o
);
  localparam int CW = (FLT_CYC < 2) ? 1 : $clog2(FLT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FLT_CYC - 1);

  logic [NP-1:0] p_hit;
  logic          a_hit;
  logic          flt_q;

  // consecutive-cycle counters, one per persistent fault
  for (genvar g = 0; g < NP; g++) begin : g_pflt
    logic [CW-1:0] cnt_q;
    assign p_hit[g] = pflt_i[g] && (cnt_q == LAST);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (!arm_i)          cnt_q <= '0;
      else if (!pflt_i[g])      cnt_q <= '0;
      else if (!p_hit[g])       cnt_q <= cnt_q + 1'b1;
    end
  end

  // accumulating counter: low cycles hold the count
  logic [CW-1:0] acc_q;
  assign a_hit = aflt_i && (acc_q == LAST);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              acc_q <= '0;
    else if (!arm_i)          acc_q <= '0;
    else if (aflt_i && !a_hit) acc_q <= acc_q + 1'b1;
  end

  assign fault_now_o = arm_i && ((|p_hit) || a_hit || nocard_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flt_q <= 1'b0;
    else if (!arm_i)      flt_q <= 1'b0;
    else if (fault_now_o) flt_q <= 1'b1;
  end

  assign fault_o = flt_q;
endmodule

// File: rtl/deact_fsm.sv
module deact_fsm
  import card_seq_pkg::*;
#(
  parameter int CLK_TO = 50,
  parameter int DAT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             off_req_i,
  input  logic             trig_i,
  input  logic             vcc_rdy_i,
  input  logic             sync_mode_i,
  input  logic             clk_fall_i,
  input  logic             rst_req_i,
  input  logic             clk_src_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic             vcc_en_o,
  output logic             card_rst_o,
  output logic             card_clk_o,
  output logic [DAT_W-1:0] card_dat_o
);
  localparam int TW = (CLK_TO < 2) ? 1 : $clog2(CLK_TO);
  localparam logic [TW-1:0] TLAST = TW'(CLK_TO - 1);

  seq_st_e       st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic          sync_q;
  logic          hold_q;
  logic          clk_done;

  assign clk_done = (tmr_q == TLAST) || (!sync_q && clk_fall_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_OFF:  if (!off_req_i && !trig_i) st_d = ST_LIVE;
      ST_LIVE: if (off_req_i || trig_i)   st_d = ST_CLKD;
      ST_CLKD: if (clk_done)              st_d = ST_DATD;
      default:                            st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_OFF;
      tmr_q  <= '0;
      sync_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_LIVE) begin
        sync_q <= sync_mode_i;
        hold_q <= card_clk_o;
        tmr_q  <= '0;
      end else if (st_q == ST_CLKD && !clk_done) begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  always_comb begin
    vcc_en_o   = 1'b0;
    card_rst_o = 1'b0;
    card_clk_o = 1'b0;
    card_dat_o = '0;
    unique case (st_q)
      ST_LIVE: begin
        vcc_en_o   = 1'b1;
        card_rst_o = rst_req_i & vcc_rdy_i;
        card_clk_o = clk_src_i & vcc_rdy_i;
        card_dat_o = dat_i & {DAT_W{vcc_rdy_i}};
      end
      ST_CLKD: begin
        vcc_en_o   = 1'b1;
        card_clk_o = (sync_q ? hold_q : clk_src_i) & vcc_rdy_i;
        card_dat_o = dat_i & {DAT_W{vcc_rdy_i}};
      end
      ST_DATD: vcc_en_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/card_deact_seq.sv
module card_deact_seq
  import card_seq_pkg::*;
#(
  parameter int DEB_CYC = 32000,
  parameter int FLT_CYC = 50,
  parameter int CLK_TO  = 50,
  parameter int DAT_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       vcc_sel_i,
  input  logic             pres_n_i,
  input  logic             flt_uv_i,
  input  logic             flt_oc_i,
  input  logic             flt_ot_i,
  input  logic             flt_rst_i,
  input  logic             flt_clk_i,
  input  logic             vcc_rdy_i,
  input  logic             sync_mode_i,
  input  logic             clk_fall_i,
  input  logic             rst_req_i,
  input  logic             clk_src_i,
  input  logic [DAT_W-1:0] dat_i,
  output logic             vcc_en_o,
  output logic             card_rst_o,
  output logic             card_clk_o,
  output logic [DAT_W-1:0] card_dat_o,
  output logic             fault_o,
  output logic             present_o
);
  logic                off_req;
  logic                present;
  logic                fault_now;
  logic                fault_q;
  logic [NUM_PFLT-1:0] pflt;

  assign off_req = (vcc_sel_i == 2'b00);
  assign pflt    = {flt_rst_i, flt_ot_i, flt_oc_i, flt_uv_i};

  pres_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pres_n_i  (pres_n_i),
    .present_o (present)
  );

  fault_qual #(.FLT_CYC(FLT_CYC), .NP(NUM_PFLT)) u_flt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (!off_req),
    .pflt_i      (pflt),
    .aflt_i      (flt_clk_i),
    .nocard_i    (pres_n_i | !present),
    .fault_now_o (fault_now),
    .fault_o     (fault_q)
  );

  deact_fsm #(.CLK_TO(CLK_TO), .DAT_W(DAT_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .off_req_i   (off_req),
    .trig_i      (fault_now | fault_q),
    .vcc_rdy_i   (vcc_rdy_i),
    .sync_mode_i (sync_mode_i),
    .clk_fall_i  (clk_fall_i),
    .rst_req_i   (rst_req_i),
    .clk_src_i   (clk_src_i),
    .dat_i       (dat_i),
    .vcc_en_o    (vcc_en_o),
    .card_rst_o  (card_rst_o),
    .card_clk_o  (card_clk_o),
    .card_dat_o  (card_dat_o)
  );

  assign fault_o   = fault_q;
  assign present_o = present;
endmodule

// File: rtl/card_deact_chk.sv
module card_deact_chk #(
  parameter int DAT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       vcc_sel_i,
  input logic             pres_n_i,
  input logic             vcc_rdy_i,
  input logic             vcc_en_o,
  input logic             card_rst_o,
  input logic             card_clk_o,
  input logic [DAT_W-1:0] card_dat_o,
  input logic             fault_o,
  input logic             present_o
);
  a_r11_gated_by_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_rst_o || card_clk_o || (card_dat_o != '0)) |-> vcc_rdy_i);

  a_r6_fault_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o && vcc_sel_i != 2'b00) |=> fault_o);

  a_r7_reset_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_en_o && vcc_sel_i == 2'b00) |=> !card_rst_o);

  a_r10_data_low_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> ($past(card_dat_o) == '0 && !$past(card_clk_o)));

  a_r5_removal_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_sel_i != 2'b00 && pres_n_i) |=> fault_o);

  a_r2_drop_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pres_n_i |=> !present_o);
endmodule

bind card_deact_seq card_deact_chk #(.DAT_W(DAT_W)) u_chk (.*);

// File: tb/sim_card_deact_seq.sv
module sim_card_deact_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 20;
  localparam int FLT = 8;
  localparam int CTO = 6;
  localparam int DW  = 3;

  typedef struct packed {
    logic [3:0] flags;  // {rst_mis, ot, oc, uv}
    logic [7:0] len;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{4'b0001, 8'd7, 1'b0},
    '{4'b0001, 8'd8, 1'b1},
    '{4'b0010, 8'd8, 1'b1},
    '{4'b0100, 8'd3, 1'b0},
    '{4'b0100, 8'd9, 1'b1},
    '{4'b1000, 8'd8, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sel = 2'b00;
  logic          pres_n = 1'b1;
  logic [3:0]    pf = '0;
  logic          fclk = 1'b0;
  logic          rdy = 1'b1;
  logic          smode = 1'b0;
  logic          cfall = 1'b0;
  logic          rreq = 1'b0;
  logic          csrc = 1'b0;
  logic [DW-1:0] dat = '0;
  logic          vcc_en, crst, cclk, fault, present;
  logic [DW-1:0] cdat;

  int total = 0;
  int fails = 0;

  card_deact_seq #(.DEB_CYC(DEB), .FLT_CYC(FLT), .CLK_TO(CTO), .DAT_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .vcc_sel_i(sel), .pres_n_i(pres_n),
    .flt_uv_i(pf[0]), .flt_oc_i(pf[1]), .flt_ot_i(pf[2]), .flt_rst_i(pf[3]),
    .flt_clk_i(fclk), .vcc_rdy_i(rdy), .sync_mode_i(smode), .clk_fall_i(cfall),
    .rst_req_i(rreq), .clk_src_i(csrc), .dat_i(dat),
    .vcc_en_o(vcc_en), .card_rst_o(crst), .card_clk_o(cclk), .card_dat_o(cdat),
    .fault_o(fault), .present_o(present)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R1 reset state
    step(2);
    chk("R1 vcc_en", vcc_en, 0);
    chk("R1 fault", fault, 0);
    chk("R1 present", present, 0);
    chk("R1 card pins", {crst, cclk, cdat}, 0);
    rst_n = 1'b1;

    // R2 debounce with an interrupting bounce
    pres_n = 1'b0; step(10);
    pres_n = 1'b1; step(1);
    chk("R2 bounce clears", present, 0);
    pres_n = 1'b0; step(DEB - 1);
    chk("R2 before window", present, 0);
    step(1);
    chk("R2 after window", present, 1);

    // R3 persistent fault table
    foreach (VECS[i]) begin
      sel = 2'b00; pf = '0; step(12);
      sel = 2'b01; step(1);
      pf = VECS[i].flags; step(int'(VECS[i].len));
      pf = '0; step(1);
      chk($sformatf("R3 vec%0d fault", i), fault, VECS[i].exp);
    end

    // R12 activation, R11 gating
    sel = 2'b00; step(12);
    rdy = 1'b0; rreq = 1'b1; csrc = 1'b1; dat = 3'b111;
    sel = 2'b01; step(1);
    chk("R12 supply on", vcc_en, 1);
    chk("R11 pins held low", {crst, cclk, cdat}, 0);
    rdy = 1'b1; step(1);
    chk("R11 pins follow", {crst, cclk, cdat}, 5'b11111);

    // R9 synchronous power-down, R7 reset first
    smode = 1'b1; step(1);
    sel = 2'b00; step(1);
    chk("R7 reset low", crst, 0);
    chk("R9 clock frozen", cclk, 1);
    chk("R10 data kept", cdat, 3'b111);
    csrc = 1'b0; step(CTO - 1);
    chk("R9 source ignored", cclk, 1);
    step(1);
    chk("R9 forced low", cclk, 0);
    chk("R10 data low", cdat, 0);
    chk("R10 supply still on", vcc_en, 1);
    step(1);
    chk("R10 supply off", vcc_en, 0);

    // R8 asynchronous, falling edge ends clock step
    smode = 1'b0; csrc = 1'b1; sel = 2'b01; step(1);
    sel = 2'b00; step(1);
    chk("R8 clock follows", cclk, 1);
    csrc = 1'b0; cfall = 1'b1; step(1);
    cfall = 1'b0;
    chk("R8 early end data low", cdat, 0);
    chk("R8 early end supply on", vcc_en, 1);
    step(1);
    chk("R8 supply off", vcc_en, 0);

    // R8 asynchronous timeout
    csrc = 1'b1; sel = 2'b01; step(1);
    sel = 2'b00; step(CTO);
    chk("R8 still running", {cclk, cdat}, 4'b1111);
    step(1);
    chk("R8 forced low", {cclk, cdat}, 0);

    // R4 accumulated clock mismatch
    step(2);
    sel = 2'b01; step(1);
    fclk = 1'b1; step(3); fclk = 1'b0; step(1);
    fclk = 1'b1; step(3); fclk = 1'b0; step(1);
    chk("R4 six counted", fault, 0);
    chk("R4 slot live", vcc_en, 1);
    fclk = 1'b1; step(1); fclk = 1'b0; step(1);
    chk("R4 seven counted", fault, 0);
    fclk = 1'b1; step(1); fclk = 1'b0;
    chk("R4 eighth sets", fault, 1);

    // R6 latch until shutdown code
    step(CTO + 6);
    chk("R6 still set", fault, 1);
    chk("R6 no repower", vcc_en, 0);
    sel = 2'b00; step(1);
    chk("R6 cleared", fault, 0);

    // R5 removal during activity
    sel = 2'b01; step(1);
    chk("R5 slot live", vcc_en, 1);
    pres_n = 1'b1; step(1);
    chk("R5 removal fault", fault, 1);
    chk("R7 reset low on fault", crst, 0);

    // R5 power request without card
    sel = 2'b00; step(CTO + 6);
    sel = 2'b01; step(1);
    chk("R5 no card fault", fault, 1);
    chk("R12 no card no supply", vcc_en, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule